// File: doc/BRIEF.md
# Hot-Swap Command and Status I2C Target

This block is a minimal I2C-compatible target for a board power controller. It answers to one 7-bit address and takes only two transfers: a one-byte write and a one-byte read. The write loads five command bits that set the controller's overrides, such as forcing power off or forcing the local reset. The read returns one byte that reflects the controller's pins and its fault code.

The address is a fixed `01` prefix followed by five bits taken from `addr_sel_i`, so 32 targets can share a bus. Both bus lines are sampled in the system clock domain through a two-flop synchronizer. START and STOP are recognised from SDA edges while SCL is high. The target never stretches the clock. It drives SDA only by pulling it low through `sda_oe_o`.

Top module: `hs_i2c_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal `{2'b01, addr_sel_i[4:0]}`. It does this by holding SDA low during the ninth clock.
- R2: For any other address the target leaves SDA released (NACK) until the next START or STOP, and `cmd_o` does not change.
- R3: In a write, command byte bit k (k = 1..5) is loaded into `cmd_o[k-1]`. Command byte bits 7, 6 and 0 have no effect.
- R4: `cmd_o` changes only on the SCL fall that ends the ACK clock of the command byte. A STOP before that point leaves `cmd_o` unchanged.
- R5: A read returns, MSB first, `{present_b_i, present_a_i, pgood_i, lreset_i, reset_in_i, fcode_i[1], fcode_i[0], fault_i}`.
- R6: The status byte is sampled on the SCL fall that ends the address ACK. Input changes after that point do not alter the byte being sent.
- R7: After reset, `cmd_o` is 0 and `sda_oe_o` is 0.
- R8: A STOP at any point releases SDA and returns the target to idle, and the next transfer is handled normally.
- R9: After the eighth data bit of a read, the target releases SDA for the master's acknowledge clock.
- R10: A repeated START during an address byte restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| addr_sel_i | input | 5 | Low five address bits |
| cmd_o | output | 5 | Command latch, cmd_o[k-1] from byte bit k |
| present_b_i | input | 1 | Second presence pin state (status bit 7) |
| present_a_i | input | 1 | First presence pin state (status bit 6) |
| pgood_i | input | 1 | Power-good pin state (status bit 5) |
| lreset_i | input | 1 | Local reset output state (status bit 4) |
| reset_in_i | input | 1 | Reset input state (status bit 3) |
| fcode_i | input | 2 | Fault source code (status bits 2:1) |
| fault_i | input | 1 | Fault pin state (status bit 0) |

## Verification
The bench aims at the following corner cases.

- **Wrong address.** Two kinds are tried: one with a wrong prefix and one with a wrong strap bit. A target that compares too few bits would acknowledge these and could corrupt the latch.
- **Latch timing.** The latch is observed on both sides of the command ACK clock, and a write is aborted halfway. A latch updated on the eighth bit, or on STOP, would show the new value too early or take a truncated byte.
- **Status snapshot.** The status inputs are changed right after the address ACK. A design that samples late would send a mix of old and new values.
- **Bus events.** A repeated START in mid-address and a STOP in mid-transfer are both applied. A design that ignores them would lose bit alignment and then NACK or misread later transfers.

// File: rtl/hs_i2c_pkg.sv
package hs_i2c_pkg;
  localparam int BYTE_W     = 8;
  localparam int SEL_W      = 5;
  localparam int CMD_W      = 5;
  localparam int CMD_LSB    = 1;
  localparam logic [1:0] ADDR_PREFIX = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDAT, ST_WACK, ST_RDAT, ST_RACK, ST_SKIP
  } state_t;
endpackage

// File: rtl/hs_i2c_sync.sv
module hs_i2c_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[g] <= RST_VAL;
      else if (g == 0) pipe_q[g] <= d_i;
      else pipe_q[g] <= pipe_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/hs_i2c_events.sv
module hs_i2c_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  // SDA edge while SCL stays high
  assign start_o = scl_q & scl_s_i & sda_q & ~sda_s_i;
  assign stop_o  = scl_q & scl_s_i & ~sda_q & sda_s_i;
  assign rise_o  = ~scl_q & scl_s_i;
  assign fall_o  = scl_q & ~scl_s_i;
endmodule

// File: rtl/hs_i2c_target.sv
module hs_i2c_target
  import hs_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [SEL_W-1:0] addr_sel_i,
  output logic [CMD_W-1:0] cmd_o,
  input  logic             present_b_i,
  input  logic             present_a_i,
  input  logic             pgood_i,
  input  logic             lreset_i,
  input  logic             reset_in_i,
  input  logic [1:0]       fcode_i,
  input  logic             fault_i
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic scl_s, sda_s;
  logic ev_start, ev_stop, scl_rise, scl_fall;

  hs_i2c_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  hs_i2c_events u_events (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_s_i(scl_s),
    .sda_s_i(sda_s),
    .start_o(ev_start),
    .stop_o (ev_stop),
    .rise_o (scl_rise),
    .fall_o (scl_fall)
  );

  state_t             state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [BYTE_W-1:0]  rx_q, tx_q;
  logic               rw_q, sda_oe_q;
  logic [CMD_W-1:0]   cmd_q;
  logic [BYTE_W-1:0]  status_w;
  logic               addr_hit;

  assign status_w = {present_b_i, present_a_i, pgood_i, lreset_i,
                     reset_in_i, fcode_i, fault_i};
  assign addr_hit = (rx_q[BYTE_W-1:1] == {ADDR_PREFIX, addr_sel_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      rw_q     <= 1'b0;
      sda_oe_q <= 1'b0;
      cmd_q    <= '0;
    end else if (ev_stop) begin
      state_q  <= ST_IDLE;
      sda_oe_q <= 1'b0;
    end else if (ev_start) begin
      state_q  <= ST_ADDR;
      cnt_q    <= '0;
      sda_oe_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            rx_q  <= {rx_q[BYTE_W-2:0], sda_s};
            cnt_q <= cnt_q + CNT_W'(1);
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            if (addr_hit) begin
              state_q  <= ST_AACK;
              sda_oe_q <= 1'b1;
              rw_q     <= rx_q[0];
            end else begin
              state_q  <= ST_SKIP;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            cnt_q <= '0;
            if (rw_q) begin
              tx_q     <= status_w;  // snapshot held for the whole byte
              sda_oe_q <= ~status_w[BYTE_W-1];
              state_q  <= ST_RDAT;
            end else begin
              sda_oe_q <= 1'b0;
              state_q  <= ST_WDAT;
            end
          end
        end
        ST_WDAT: begin
          if (scl_rise) begin
            rx_q  <= {rx_q[BYTE_W-2:0], sda_s};
            cnt_q <= cnt_q + CNT_W'(1);
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            state_q  <= ST_WACK;
            sda_oe_q <= 1'b1;
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            cmd_q    <= rx_q[CMD_LSB +: CMD_W];
            sda_oe_q <= 1'b0;
            state_q  <= ST_SKIP;
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            if (cnt_q == CNT_LAST) begin
              sda_oe_q <= 1'b0;
              state_q  <= ST_RACK;
            end else begin
              tx_q     <= {tx_q[BYTE_W-2:0], 1'b0};
              sda_oe_q <= ~tx_q[BYTE_W-2];
              cnt_q    <= cnt_q + CNT_W'(1);
            end
          end
        end
        ST_RACK: begin
          if (scl_fall) state_q <= ST_SKIP;
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = sda_oe_q;
  assign cmd_o    = cmd_q;

  p_reset_state_r7: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (cmd_q == '0) && !sda_oe_q);

  p_addr_ack_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_AACK) |-> sda_oe_q);

  p_skip_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SKIP) |-> !sda_oe_q);

  p_cmd_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(state_q == ST_WACK && scl_fall) |=> $stable(cmd_q));

  p_snapshot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RDAT && !scl_fall) |=> $stable(tx_q));

  p_stop_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_stop |=> (state_q == ST_IDLE) && !sda_oe_q);

  p_rd_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RACK) |-> !sda_oe_q);

  p_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_start && !ev_stop) |=> (state_q == ST_ADDR) && (cnt_q == '0));
endmodule

// File: tb/hs_i2c_target_test.sv
module hs_i2c_target_test;
  localparam int H = 8;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [4:0] sel = 5'b10110;
  logic [4:0] cmd;
  logic [7:0] stat = 8'h00;

  int checks = 0, failures = 0, cyc = 0;
  logic done = 1'b0, cmd_busy = 1'b0, quiet = 1'b0;
  logic [4:0] exp_cmd = 5'h00;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  hs_i2c_target uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .addr_sel_i(sel), .cmd_o(cmd),
    .present_b_i(stat[7]), .present_a_i(stat[6]), .pgood_i(stat[5]),
    .lreset_i(stat[4]), .reset_in_i(stat[3]), .fcode_i(stat[2:1]),
    .fault_i(stat[0])
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_c();
    sda_m = 1'b1; wait_clk(H);
    scl_m = 1'b1; wait_clk(H);
    sda_m = 1'b0; wait_clk(H);
    scl_m = 1'b0; wait_clk(H);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; wait_clk(H);
    scl_m = 1'b1; wait_clk(H);
    sda_m = 1'b1; wait_clk(H);
  endtask

  task automatic bit_c(input logic b, output logic s);
    sda_m = b; wait_clk(H);
    scl_m = 1'b1; wait_clk(H);
    s = sda_line;
    scl_m = 1'b0; wait_clk(H);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_c(b[i], s);
    bit_c(1'b1, ack);
  endtask

  task automatic rd_byte(output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_c(1'b1, s);
      d[i] = s;
    end
    // master NACK clock; target must be silent (R9)
    sda_m = 1'b1; wait_clk(H);
    scl_m = 1'b1; wait_clk(H/2);
    chk("R9 release on master ack clock", {7'b0, sda_oe}, 8'h00);
    wait_clk(H/2);
    scl_m = 1'b0; wait_clk(H);
  endtask

  task automatic wr_txn(input logic [7:0] a, input logic [7:0] d, input logic hit,
                        output logic ack_a, output logic ack_d);
    cmd_busy = 1'b1;
    start_c();
    wr_byte(a, ack_a);
    wr_byte(d, ack_d);
    stop_c();
    if (hit) exp_cmd = d[5:1];
    wait_clk(4);
    cmd_busy = 1'b0;
  endtask

  task automatic rd_txn(input logic [7:0] a, output logic ack_a, output logic [7:0] d);
    start_c();
    wr_byte(a, ack_a);
    rd_byte(d);
    stop_c();
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      if (!cmd_busy) begin
        checks++;
        if (cmd !== exp_cmd) begin
          failures++;
          $display("FAIL R4 cmd changed outside write ack actual=%h expected=%h", cmd, exp_cmd);
        end
      end
      if (quiet) begin
        checks++;
        if (sda_oe !== 1'b0) begin
          failures++;
          $display("FAIL R2 sda driven for foreign address actual=%b expected=0", sda_oe);
        end
      end
    end
    if (cyc > WD_LIMIT && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WD_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic aa, ad, s;
    logic [7:0] d;
    wait_clk(4);
    chk("R7 reset cmd", {3'b0, cmd}, 8'h00);
    chk("R7 reset sda", {7'b0, sda_oe}, 8'h00);
    rst_n = 1'b1;
    wait_clk(4);

    // address 0110110 -> 0x6C write, 0x6D read
    wr_txn(8'h6C, 8'h2A, 1'b1, aa, ad);
    chk("R1 addr ack", {7'b0, aa}, 8'h00);
    chk("R3 cmd from 0x2A", {3'b0, cmd}, 8'h15);
    wr_txn(8'h6C, 8'hC1, 1'b1, aa, ad);
    chk("R3 ignored bits 7,6,0", {3'b0, cmd}, 8'h00);
    wr_txn(8'h6C, 8'h3E, 1'b1, aa, ad);
    chk("R3 all command bits", {3'b0, cmd}, 8'h1F);

    // foreign addresses
    quiet = 1'b1;
    wr_txn(8'h6E, 8'h00, 1'b0, aa, ad);
    chk("R2 nack strap mismatch", {7'b0, aa}, 8'h01);
    wr_txn(8'hEC, 8'h00, 1'b0, aa, ad);
    chk("R2 nack prefix mismatch", {7'b0, aa}, 8'h01);
    quiet = 1'b0;
    chk("R2 cmd unchanged", {3'b0, cmd}, 8'h1F);

    // latch timing around the command ack clock
    cmd_busy = 1'b1;
    start_c();
    wr_byte(8'h6C, aa);
    for (int i = 7; i >= 0; i--) bit_c(i == 2 || i == 1, s); // 0x06 -> cmd 0x03
    sda_m = 1'b1; wait_clk(H);
    scl_m = 1'b1; wait_clk(H);
    chk("R1 data ack", {7'b0, sda_line}, 8'h00);
    chk("R4 cmd before ack fall", {3'b0, cmd}, 8'h1F);
    scl_m = 1'b0; wait_clk(H);
    chk("R4 cmd after ack fall", {3'b0, cmd}, 8'h03);
    stop_c();
    exp_cmd = 5'h03;
    wait_clk(4);
    cmd_busy = 1'b0;

    // aborted write
    start_c();
    wr_byte(8'h6C, aa);
    for (int i = 0; i < 4; i++) bit_c(1'b1, s);
    stop_c();
    wait_clk(4);
    chk("R4 abort keeps cmd", {3'b0, cmd}, 8'h03);
    chk("R8 released after stop", {7'b0, sda_oe}, 8'h00);

    // reads
    stat = 8'hA5;
    rd_txn(8'h6D, aa, d);
    chk("R1 read addr ack", {7'b0, aa}, 8'h00);
    chk("R5 status 0xA5", d, 8'hA5);
    stat = 8'h5A;
    rd_txn(8'h6D, aa, d);
    chk("R5 status 0x5A", d, 8'h5A);

    // snapshot
    stat = 8'h3C;
    start_c();
    wr_byte(8'h6D, aa);
    stat = 8'hC3;
    rd_byte(d);
    stop_c();
    chk("R6 snapshot kept", d, 8'h3C);

    // stop mid read, then normal write
    stat = 8'hFF;
    start_c();
    wr_byte(8'h6D, aa);
    for (int i = 0; i < 3; i++) bit_c(1'b1, s);
    stop_c();
    wait_clk(4);
    chk("R8 idle after stop in read", {7'b0, sda_oe}, 8'h00);
    wr_txn(8'h6C, 8'h08, 1'b1, aa, ad);
    chk("R8 next write acked", {6'b0, aa, ad}, 8'h00);
    chk("R8 next write loads", {3'b0, cmd}, 8'h04);

    // repeated start in address phase
    cmd_busy = 1'b1;
    start_c();
    for (int i = 0; i < 4; i++) bit_c(i[0], s);
    start_c();
    wr_byte(8'h6C, aa);
    wr_byte(8'h10, ad);
    stop_c();
    exp_cmd = 5'h08;
    wait_clk(4);
    cmd_busy = 1'b0;
    chk("R10 ack after restart", {6'b0, aa, ad}, 8'h00);
    chk("R10 cmd after restart", {3'b0, cmd}, 8'h08);

    // other strap value: address 0100001 -> 0x42
    sel = 5'b00001;
    wait_clk(4);
    wr_txn(8'h42, 8'h02, 1'b1, aa, ad);
    chk("R1 other strap ack", {7'b0, aa}, 8'h00);
    chk("R3 other strap cmd", {3'b0, cmd}, 8'h01);

    wait_clk(10);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule